// File: doc/BRIEF.md
# Serial EEPROM Status and Write Guard

This unit keeps the status byte of a serial EEPROM and decides whether a write to the array or to the status register may go ahead. The serial engine decodes the instructions and hands it single-cycle strobes: set the write latch, clear the write latch, commit a status write (with its data byte), commit an array write (with its target address), and end of the internal write cycle. The unit also samples the external write-protect pin, which is active low.

The unit answers with three things. The status byte is what a status read shifts out. The array permission flag is computed for the address currently presented. The status permission flag says whether a status write would be taken. The protection and lock bits are nonvolatile. They are held in registers that reset does not touch, so they keep their values across a reset. Their start-up value comes from parameters. Reset clears only the write latch and the busy flag.

A commit is acted on at the rising clock edge where its strobe is high. The new status shows on `status_o` after that edge. The permission flags are combinational and follow the current state and inputs.

Top module: `eeprom_status_guard`

## Requirements
- R1: Reset clears the write latch and the busy flag. The protection bits and the lock-enable bit keep their values through reset, and start at `INIT_WPEN` / `INIT_BP`.
- R2: The status byte is laid out as bit 7 lock enable, bits 3:2 protection level, bit 1 write latch, bit 0 busy. Bits 6:4 always read 0, and whatever a status write puts in bits 6:4, 1 and 0 is thrown away.
- R3: `set_wel_i` sets the write latch and `clr_wel_i` clears it. If both are high in the same cycle, the latch ends up clear.
- R4: The set and clear strobes act whatever the protection level, the lock state or the busy flag.
- R5: Protection level 00 protects nothing. Level 01 protects addresses whose top two bits are 11 (0x6000-0x7FFF with 15 bits). Level 10 protects addresses whose top bit is 1 (0x4000-0x7FFF). Level 11 protects the whole array. `arr_wr_ok_o` is 0 for a protected address.
- R6: Both permission flags are 0 while the write latch is clear or the busy flag is set.
- R7: An array commit that is permitted sets busy and clears the write latch. A commit that is not permitted changes nothing.
- R8: The status register is locked (`sr_wr_ok_o` = 0) when the lock-enable bit is 1 and `wp_n_i` is low. When the lock-enable bit is 0, the pin has no effect.
- R9: A status commit that is permitted loads bit 7 and bits 3:2 of `sr_data_i`, sets busy and clears the write latch. A status commit that is refused changes nothing.
- R10: Busy stays set until `cycle_done_i`, which clears it. Changes on the write-protect pin during the cycle do not affect it.
- R11: A commit is judged with the write latch value held before its clock edge. A set strobe in the same cycle therefore cannot admit it, and the set itself still takes effect.
- R12: When a status commit and an array commit arrive in the same cycle, only the status commit is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wp_n_i | input | 1 | Write-protect pin, active low |
| set_wel_i | input | 1 | Set-latch strobe |
| clr_wel_i | input | 1 | Clear-latch strobe |
| sr_commit_i | input | 1 | Status write commit strobe |
| sr_data_i | input | 8 | Data byte of the status write |
| arr_commit_i | input | 1 | Array write commit strobe |
| arr_addr_i | input | ADDR_W | Target array address |
| cycle_done_i | input | 1 | End of internal write cycle |
| status_o | output | 8 | Status byte |
| arr_wr_ok_o | output | 1 | Array write permitted for `arr_addr_i` |
| sr_wr_ok_o | output | 1 | Status write permitted |

## Verification
The interesting collision is a set-latch strobe that lands in the same cycle as a commit. This is what the unit sees when a write follows the enable instruction without the select line going high between them. The bench raises both strobes on one edge while the latch is clear. It then expects the status to show the latch set and no busy flag, because the commit was refused. A second case drives set and clear together and expects the latch clear. A third drives both commit kinds together and expects only the status bits to change.

// File: rtl/esg_pkg.sv
package esg_pkg;

    typedef struct packed {
        logic       wpen;
        logic [2:0] rsvd;
        logic [1:0] bp;
        logic       wel;
        logic       wip;
    } stat_t;

    typedef enum logic [1:0] {
        PROT_NONE = 2'b00,
        PROT_QTR  = 2'b01,
        PROT_HALF = 2'b10,
        PROT_ALL  = 2'b11
    } prot_e;

    // top2 holds the two most significant address bits
    function automatic logic addr_protected(prot_e lvl, logic [1:0] top2);
        logic hit;
        case (lvl)
            PROT_NONE: hit = 1'b0;
            PROT_QTR:  hit = (top2 == 2'b11);
            PROT_HALF: hit = top2[1];
            default:   hit = 1'b1;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/esg_wel_latch.sv
module esg_wel_latch (
    input  logic clk_i,
    input  logic rst_i,
    input  logic set_i,
    input  logic clr_i,
    output logic wel_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i)      wel_o <= 1'b0;
        else if (clr_i) wel_o <= 1'b0;
        else if (set_i) wel_o <= 1'b1;
    end
endmodule

// File: rtl/esg_nv_bits.sv
module esg_nv_bits #(
    parameter logic       INIT_WPEN = 1'b0,
    parameter logic [1:0] INIT_BP   = 2'b00
) (
    input  logic       clk_i,
    input  logic       load_i,
    input  logic       wpen_i,
    input  logic [1:0] bp_i,
    output logic       wpen_o,
    output logic [1:0] bp_o
);
    // nonvolatile model: no reset term, power-up value only
    logic       wpen_q = INIT_WPEN;
    logic [1:0] bp_q   = INIT_BP;

    always_ff @(posedge clk_i) begin
        if (load_i) begin
            wpen_q <= wpen_i;
            bp_q   <= bp_i;
        end
    end

    assign wpen_o = wpen_q;
    assign bp_o   = bp_q;
endmodule

// File: rtl/esg_wip_flag.sv
module esg_wip_flag (
    input  logic clk_i,
    input  logic rst_i,
    input  logic start_i,
    input  logic done_i,
    output logic wip_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i)        wip_o <= 1'b0;
        else if (start_i) wip_o <= 1'b1;
        else if (done_i)  wip_o <= 1'b0;
    end
endmodule

// File: rtl/esg_guard_decode.sv
module esg_guard_decode
    import esg_pkg::*;
(
    input  logic       wel_i,
    input  logic       wip_i,
    input  logic       wpen_i,
    input  logic [1:0] bp_i,
    input  logic       wp_n_i,
    input  logic [1:0] addr_top_i,
    output logic       arr_ok_o,
    output logic       sr_ok_o
);
    logic ready;
    logic hw_lock;
    logic blk_hit;

    always_comb begin
        ready    = wel_i & ~wip_i;
        hw_lock  = wpen_i & ~wp_n_i;
        blk_hit  = addr_protected(prot_e'(bp_i), addr_top_i);
        arr_ok_o = ready & ~blk_hit;
        sr_ok_o  = ready & ~hw_lock;
    end
endmodule

// File: rtl/eeprom_status_guard.sv
module eeprom_status_guard
    import esg_pkg::*;
#(
    parameter int         ADDR_W    = 15,
    parameter logic       INIT_WPEN = 1'b0,
    parameter logic [1:0] INIT_BP   = 2'b00
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wp_n_i,
    input  logic              set_wel_i,
    input  logic              clr_wel_i,
    input  logic              sr_commit_i,
    input  logic [7:0]        sr_data_i,
    input  logic              arr_commit_i,
    input  logic [ADDR_W-1:0] arr_addr_i,
    input  logic              cycle_done_i,
    output logic [7:0]        status_o,
    output logic              arr_wr_ok_o,
    output logic              sr_wr_ok_o
);
    localparam int LOW_W = ADDR_W - 2;

    stat_t      req;
    stat_t      stat;
    logic       wel, wip, wpen;
    logic [1:0] bp;
    logic [1:0] addr_top;
    logic       take_sr, take_arr, wel_clear;

    logic [LOW_W-1:0] unused_addr_low;
    logic [4:0]       unused_req_bits;

    assign req             = stat_t'(sr_data_i);
    assign addr_top        = arr_addr_i[ADDR_W-1 -: 2];
    assign unused_addr_low = arr_addr_i[LOW_W-1:0];
    assign unused_req_bits = {req.rsvd, req.wel, req.wip};

    esg_guard_decode u_dec (
        .wel_i      (wel),
        .wip_i      (wip),
        .wpen_i     (wpen),
        .bp_i       (bp),
        .wp_n_i     (wp_n_i),
        .addr_top_i (addr_top),
        .arr_ok_o   (arr_wr_ok_o),
        .sr_ok_o    (sr_wr_ok_o)
    );

    // status commit outranks a concurrent array commit
    assign take_sr   = sr_commit_i & sr_wr_ok_o;
    assign take_arr  = arr_commit_i & arr_wr_ok_o & ~sr_commit_i;
    assign wel_clear = clr_wel_i | take_sr | take_arr;

    esg_wel_latch u_wel (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .set_i (set_wel_i),
        .clr_i (wel_clear),
        .wel_o (wel)
    );

    esg_nv_bits #(
        .INIT_WPEN (INIT_WPEN),
        .INIT_BP   (INIT_BP)
    ) u_nv (
        .clk_i  (clk_i),
        .load_i (take_sr),
        .wpen_i (req.wpen),
        .bp_i   (req.bp),
        .wpen_o (wpen),
        .bp_o   (bp)
    );

    esg_wip_flag u_wip (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .start_i (take_sr | take_arr),
        .done_i  (cycle_done_i),
        .wip_o   (wip)
    );

    always_comb begin
        stat      = '0;
        stat.wpen = wpen;
        stat.bp   = bp;
        stat.wel  = wel;
        stat.wip  = wip;
    end

    assign status_o = stat;
endmodule

// File: rtl/esg_checker.sv
module esg_checker (
    input logic       clk_i,
    input logic       rst_i,
    input logic       wp_n_i,
    input logic       clr_wel_i,
    input logic       sr_commit_i,
    input logic       arr_commit_i,
    input logic       cycle_done_i,
    input logic [7:0] status_o,
    input logic       arr_wr_ok_o,
    input logic       sr_wr_ok_o
);
    a_r2_rsvd_zero: assert property (@(posedge clk_i) disable iff (rst_i)
        status_o[6:4] == 3'b000);

    a_r3_clear_wins: assert property (@(posedge clk_i) disable iff (rst_i)
        clr_wel_i |=> !status_o[1]);

    a_r6_latch_gate: assert property (@(posedge clk_i) disable iff (rst_i)
        !status_o[1] |-> (!arr_wr_ok_o && !sr_wr_ok_o));

    a_r6_busy_gate: assert property (@(posedge clk_i) disable iff (rst_i)
        status_o[0] |-> (!arr_wr_ok_o && !sr_wr_ok_o));

    a_r7_start: assert property (@(posedge clk_i) disable iff (rst_i)
        (arr_commit_i && arr_wr_ok_o && !sr_commit_i) |=> (status_o[0] && !status_o[1]));

    a_r8_hw_lock: assert property (@(posedge clk_i) disable iff (rst_i)
        (status_o[7] && !wp_n_i) |-> !sr_wr_ok_o);

    a_r9_nv_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        !(sr_commit_i && sr_wr_ok_o) |=> $stable({status_o[7], status_o[3:2]}));

    a_r10_busy_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        (status_o[0] && !cycle_done_i) |=> status_o[0]);
endmodule

bind eeprom_status_guard esg_checker u_chk (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .wp_n_i       (wp_n_i),
    .clr_wel_i    (clr_wel_i),
    .sr_commit_i  (sr_commit_i),
    .arr_commit_i (arr_commit_i),
    .cycle_done_i (cycle_done_i),
    .status_o     (status_o),
    .arr_wr_ok_o  (arr_wr_ok_o),
    .sr_wr_ok_o   (sr_wr_ok_o)
);

// File: tb/eeprom_status_guard_tb_top.sv
module eeprom_status_guard_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 15;

    typedef struct {
        logic [7:0] st;
        string      tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wp_n = 1'b1;
    logic          set_wel = 1'b0, clr_wel = 1'b0;
    logic          sr_commit = 1'b0, arr_commit = 1'b0, done = 1'b0;
    logic [7:0]    sr_data = 8'h00;
    logic [AW-1:0] addr = '0;
    logic [7:0]    status;
    logic          arr_ok, sr_ok;

    int    n_run = 0;
    int    n_fail = 0;
    item_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    eeprom_status_guard #(.ADDR_W(AW)) dut_i (
        .clk_i        (clk),
        .rst_i        (rst),
        .wp_n_i       (wp_n),
        .set_wel_i    (set_wel),
        .clr_wel_i    (clr_wel),
        .sr_commit_i  (sr_commit),
        .sr_data_i    (sr_data),
        .arr_commit_i (arr_commit),
        .arr_addr_i   (addr),
        .cycle_done_i (done),
        .status_o     (status),
        .arr_wr_ok_o  (arr_ok),
        .sr_wr_ok_o   (sr_ok)
    );

    // monitor: compare status a quarter period after each edge
    always @(posedge clk) begin
        item_t it;
        #(CLK_PERIOD/4);
        if (q.size() > 0) begin
            it = q.pop_front();
            n_run++;
            if (status !== it.st) begin
                n_fail++;
                $display("FAIL %s status actual=%h expected=%h", it.tag, status, it.st);
            end
        end
    end

    // driver: inputs already set at a falling edge; queue expectation, pass one edge
    task automatic go(input logic [7:0] exp_st, input string tag);
        item_t it;
        it.st  = exp_st;
        it.tag = tag;
        q.push_back(it);
        @(negedge clk);
        set_wel = 0; clr_wel = 0; sr_commit = 0; arr_commit = 0; done = 0;
    endtask

    task automatic perm(input logic exp_arr, input logic exp_sr, input string tag);
        #1;
        n_run++;
        if (arr_ok !== exp_arr || sr_ok !== exp_sr) begin
            n_fail++;
            $display("FAIL %s perm actual=%b%b expected=%b%b", tag, arr_ok, sr_ok, exp_arr, exp_sr);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        go(8'h00, "R1 reset state");
        perm(0, 0, "R6 latch clear");
        arr_commit = 1; addr = 15'h0000;
        go(8'h00, "R7 refused commit");
        set_wel = 1; arr_commit = 1;
        go(8'h02, "R11 set with commit");
        addr = 15'h7FFF;
        perm(1, 1, "R5 level 00");
        arr_commit = 1; addr = 15'h1234;
        go(8'h01, "R7 accepted commit");
        perm(0, 0, "R6 busy");
        set_wel = 1;
        go(8'h03, "R4 set while busy");
        arr_commit = 1;
        go(8'h03, "R6 commit while busy");
        wp_n = 0;
        go(8'h03, "R10 pin change while busy");
        wp_n = 1; done = 1;
        go(8'h02, "R10 done");
        sr_commit = 1; sr_data = 8'hFF;
        go(8'h8D, "R9 R2 status load");
        done = 1;
        go(8'h8C, "R10 done after status");
        set_wel = 1;
        go(8'h8E, "R3 set");
        addr = 15'h0000;
        perm(0, 1, "R5 level 11 / R8 pin high");
        wp_n = 0;
        perm(0, 0, "R8 locked");
        sr_commit = 1; sr_data = 8'h00;
        go(8'h8E, "R8 locked commit refused");
        set_wel = 1; clr_wel = 1;
        go(8'h8C, "R3 R4 clear wins under lock");
        set_wel = 1; wp_n = 1;
        go(8'h8E, "R4 set");
        sr_commit = 1; sr_data = 8'h04;
        go(8'h05, "R9 level 01");
        done = 1;
        go(8'h04, "R10 done");
        set_wel = 1;
        go(8'h06, "R3 set");
        wp_n = 0;
        perm(1, 1, "R8 pin ignored");
        addr = 15'h6000;
        perm(0, 1, "R5 level 01 edge");
        addr = 15'h5FFF;
        perm(1, 1, "R5 level 01 below");
        sr_commit = 1; sr_data = 8'h08; arr_commit = 1;
        go(8'h09, "R12 both commits");
        done = 1;
        go(8'h08, "R10 done");
        set_wel = 1;
        go(8'h0A, "R3 set");
        addr = 15'h4000;
        perm(0, 1, "R5 level 10 edge");
        addr = 15'h3FFF;
        perm(1, 1, "R5 level 10 below");
        clr_wel = 1;
        go(8'h08, "R3 clear");
        perm(0, 0, "R6 after clear");
        set_wel = 1;
        go(8'h0A, "R3 set");
        rst = 1;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
        go(8'h08, "R1 nv retained");
        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule